// File: doc/BRIEF.md
# Linear Array Pixel Readout Control

This block is the digital sequencer of a linear light sensor with a parameterised pixel count (128 by default). A single serial start bit, sampled on a rising clock edge while the block is idle, loads a one-hot token into a shift register. The token then advances one stage per clock, and the stage it occupies names the pixel whose stored charge drives the analog output. The photodiodes, integrators, sampling nodes and output amplifier are not modelled. Each is stood in for by its digital control line.

Along with the token, a start fires a one-clock hold strobe that detaches every sampling node from its integrator at the same moment. It also opens an integrator-clear window of fixed length, after which integration resumes. An output-enable flag represents the analog output being driven rather than high impedance. An 8-bit pixel index reports the selected pixel, counted from 1, and reads 0 whenever the output is not enabled. A start that arrives while a readout is in progress is ignored and sets a sticky protocol-error flag.

Top module: `lar_readout_ctrl`

## Requirements
- R1: When `start_in` is 1 at a rising edge while no readout is in progress, the cycle after that edge (capture edge, edge 1) shows `out_en`=1, `pix_idx`=1 and `hold_strobe`=1.
- R2: `hold_strobe` is high for exactly one cycle per accepted start, the cycle after the capture edge, and is low otherwise.
- R3: After the n-th rising edge of a readout (n = 1 to 128, counting the capture edge as 1), `pix_idx` equals n, so the pixels are selected in ascending order, one per clock.
- R4: `integ_clear` is high for exactly the 18 cycles following edges 1 to 18. From edge 19 onward `integrating` is 1, and it stays 1 until the next accepted start. The two signals are never high together.
- R5: At edge 129 the token leaves the register. After that edge `out_en`=0 and `pix_idx`=0, and the block is idle.
- R6: A start presented at edge 130, the edge right after the one that ends the readout, is accepted like any other idle start.
- R7: `start_in`=1 at any edge while a readout is in progress (from edge 2 through edge 129) does not disturb the running sequence. It sets `proto_err`, which stays 1 until reset.
- R8: A synchronous active-high `rst` clears the token, output enable, hold strobe, clear window, integrating flag and protocol error, including in the middle of a readout.
- R9: While idle, `pix_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_in | input | 1 | Serial start bit |
| hold_strobe | output | 1 | One-cycle pulse that detaches all sampling nodes |
| integ_clear | output | 1 | Integrator clear window |
| integrating | output | 1 | Integration period in progress |
| out_en | output | 1 | Output driven (low means high impedance) |
| pix_idx | output | 8 | Selected pixel, 1-based, 0 when idle |
| proto_err | output | 1 | Sticky flag for a start received while busy |

## Verification
Several properties are checked on every cycle by assertions:
- the token is one-hot or empty, and advances exactly one stage per edge;
- the output enable agrees with token occupancy;
- the hold strobe is a single-cycle pulse that coincides with pixel 1;
- the clear window and the integrating flag exclude each other;
- a busy-time start always raises the sticky error.

Only the bench scenarios can show the absolute timing: the 18-cycle clear length, the release at edge 129, acceptance at edge 130, that an ignored start leaves the pixel order unchanged, and that reset clears state in the middle of a readout.

// File: rtl/lar_pkg.sv
package lar_pkg;

    localparam int unsigned PIX_COUNT_DEF  = 128;
    localparam int unsigned CLEAR_LEN_DEF  = 18;

    // readout phase, as seen by the start detector
    typedef enum logic {
        PH_IDLE    = 1'b0,
        PH_READOUT = 1'b1
    } phase_e;

    // integrator-side control state
    typedef struct packed {
        logic clear;
        logic integ;
    } integ_flags_t;

    function automatic phase_e phase_of(input logic busy);
        return busy ? PH_READOUT : PH_IDLE;
    endfunction

endpackage

// File: rtl/lar_start_detect.sv
module lar_start_detect
    import lar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_in,
    input  logic busy,
    output logic accept,
    output logic hold_strobe,
    output logic proto_err
);

    phase_e phase;

    always_comb begin
        phase  = phase_of(busy);
        accept = start_in && (phase == PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_strobe <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            hold_strobe <= accept;
            if (start_in && phase == PH_READOUT)
                proto_err <= 1'b1;
        end
    end

    // R2: the strobe never lasts two cycles
    p_hold_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |=> !hold_strobe);

    // R7: a busy-time start always flags an error, and the flag stays set
    p_busy_start_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (start_in && busy) |=> proto_err);
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

endmodule

// File: rtl/lar_token_shift.sv
module lar_token_shift #(
    parameter int unsigned NUM_PIX = 128,
    parameter int unsigned IDX_W   = $clog2(NUM_PIX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic             busy,
    output logic             out_en,
    output logic [IDX_W-1:0] pix_idx
);

    localparam int unsigned LAST = NUM_PIX - 1;

    logic [NUM_PIX-1:0] tok;
    logic [IDX_W-1:0]   idx_raw;

    // one flop per pixel stage
    for (genvar g = 0; g < NUM_PIX; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) tok[g] <= 1'b0;
                else     tok[g] <= load;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) tok[g] <= 1'b0;
                else     tok[g] <= tok[g-1];
            end
        end
    end

    // enable: set on load, released when the token leaves the last stage
    always_ff @(posedge clk) begin
        if (rst)            out_en <= 1'b0;
        else if (load)      out_en <= 1'b1;
        else if (tok[LAST]) out_en <= 1'b0;
    end

    always_comb begin
        idx_raw = '0;
        for (int i = 0; i < NUM_PIX; i++)
            if (tok[i]) idx_raw = idx_raw | IDX_W'(i + 1);
    end

    assign busy    = |tok;
    assign pix_idx = out_en ? idx_raw : '0;

    // R3: at most one stage occupied, and it moves up one stage per edge
    p_token_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok));
    p_token_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !tok[LAST]) |=> (tok == ($past(tok) << 1)));

    // R5: enable register agrees with token occupancy
    p_enable_matches_r5: assert property (@(posedge clk) disable iff (rst)
        out_en == busy);

endmodule

// File: rtl/lar_clear_window.sv
module lar_clear_window
    import lar_pkg::*;
#(
    parameter int unsigned CLEAR_LEN = 18,
    parameter int unsigned CNT_W     = $clog2(CLEAR_LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic integ_clear,
    output logic integrating
);

    integ_flags_t     st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            cnt <= '0;
        end else if (start) begin
            st.clear <= 1'b1;
            st.integ <= 1'b0;
            cnt      <= CNT_W'(1);
        end else if (st.clear) begin
            if (cnt == CNT_W'(CLEAR_LEN)) begin
                st.clear <= 1'b0;
                st.integ <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign integ_clear = st.clear;
    assign integrating = st.integ;

    // R4: clear and integrate exclude each other; the window does not end early
    p_clear_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(integ_clear && integrating));
    p_clear_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (integ_clear && cnt < CNT_W'(CLEAR_LEN)) |=> integ_clear);

endmodule

// File: rtl/lar_readout_ctrl.sv
module lar_readout_ctrl
    import lar_pkg::*;
#(
    parameter int unsigned NUM_PIX   = PIX_COUNT_DEF,
    parameter int unsigned CLEAR_LEN = CLEAR_LEN_DEF,
    parameter int unsigned IDX_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    output logic             hold_strobe,
    output logic             integ_clear,
    output logic             integrating,
    output logic             out_en,
    output logic [IDX_W-1:0] pix_idx,
    output logic             proto_err
);

    logic busy;
    logic accept;

    lar_start_detect u_start (
        .clk         (clk),
        .rst         (rst),
        .start_in    (start_in),
        .busy        (busy),
        .accept      (accept),
        .hold_strobe (hold_strobe),
        .proto_err   (proto_err)
    );

    lar_token_shift #(
        .NUM_PIX (NUM_PIX),
        .IDX_W   (IDX_W)
    ) u_token (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .busy    (busy),
        .out_en  (out_en),
        .pix_idx (pix_idx)
    );

    lar_clear_window #(
        .CLEAR_LEN (CLEAR_LEN)
    ) u_clear (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .integ_clear (integ_clear),
        .integrating (integrating)
    );

    // R1: the strobe cycle is the first pixel of a readout
    p_hold_first_pixel_r1: assert property (@(posedge clk) disable iff (rst)
        hold_strobe |-> (out_en && pix_idx == IDX_W'(1)));

    // R9: nothing is selected while idle
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pix_idx == '0));

endmodule

// File: tb/sim_lar_readout_ctrl.sv
module sim_lar_readout_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_in = 1'b0;
    logic       hold_strobe, integ_clear, integrating, out_en, proto_err;
    logic [7:0] pix_idx;

    int checks   = 0;
    int failures = 0;
    int edge_n   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;  // 250 MHz

    lar_readout_ctrl u0 (
        .clk(clk), .rst(rst), .start_in(start_in),
        .hold_strobe(hold_strobe), .integ_clear(integ_clear),
        .integrating(integrating), .out_en(out_en),
        .pix_idx(pix_idx), .proto_err(proto_err)
    );

    // row: edge, out_en, pix_idx, integ_clear, integrating, hold_strobe
    localparam logic [19:0] VEC [8] = '{
        {8'd1,   1'b1, 8'd1,   1'b1, 1'b0, 1'b1},
        {8'd2,   1'b1, 8'd2,   1'b1, 1'b0, 1'b0},
        {8'd18,  1'b1, 8'd18,  1'b1, 1'b0, 1'b0},
        {8'd19,  1'b1, 8'd19,  1'b0, 1'b1, 1'b0},
        {8'd64,  1'b1, 8'd64,  1'b0, 1'b1, 1'b0},
        {8'd127, 1'b1, 8'd127, 1'b0, 1'b1, 1'b0},
        {8'd128, 1'b1, 8'd128, 1'b0, 1'b1, 1'b0},
        {8'd129, 1'b0, 8'd0,   1'b0, 1'b1, 1'b0}
    };

    function automatic logic [12:0] obs();
        return {out_en, pix_idx, integ_clear, integrating, hold_strobe, proto_err};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        edge_n++;
    endtask

    task automatic chk(input string tag, input logic [12:0] exp);
        checks++;
        if (obs() !== exp) begin
            failures++;
            $display("FAIL %s: got oe/idx/clr/int/hold/err=%b expected %b", tag, obs(), exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        step(); step();
        rst = 1'b0;
        chk("R8 reset state", 13'b0);

        // R9: idle, no start
        step();
        chk("R9 idle index zero", 13'b0);

        // table walk of one full readout: R1 R2 R3 R4 R5
        edge_n   = 0;
        start_in = 1'b1;
        step();
        start_in = 1'b0;
        for (int k = 0; k < 8; k++) begin
            while (edge_n < int'(VEC[k][19:12])) step();
            chk("R1 R2 R3 R4 R5 table", {VEC[k][11:0], 1'b0});
        end

        // R6: start at edge 130 is accepted
        edge_n   = 0;
        start_in = 1'b1;
        step();
        chk("R6 start at edge 130", {1'b1, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0});

        // R7: start still high at edge 2 is ignored and flagged
        step();
        start_in = 1'b0;
        chk("R7 held start ignored", {1'b1, 8'd2, 1'b1, 1'b0, 1'b0, 1'b1});

        // R7: mid-readout start does not restart the sequence
        while (edge_n < 40) step();
        start_in = 1'b1;
        step();
        start_in = 1'b0;
        chk("R7 mid start ignored", {1'b1, 8'd41, 1'b0, 1'b1, 1'b0, 1'b1});

        // R7 R5: start at edge 129 ignored, readout still ends
        while (edge_n < 128) step();
        start_in = 1'b1;
        step();
        start_in = 1'b0;
        chk("R5 R7 end despite start", {1'b0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1});

        // R9: stays idle afterwards
        step();
        chk("R9 idle after readout", {1'b0, 8'd0, 1'b0, 1'b1, 1'b0, 1'b1});

        // R8: reset clears the sticky error
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R8 reset clears error", 13'b0);

        // R8: reset in the middle of a readout
        edge_n   = 0;
        start_in = 1'b1;
        step();
        start_in = 1'b0;
        while (edge_n < 5) step();
        chk("R3 R4 before reset", {1'b1, 8'd5, 1'b1, 1'b0, 1'b0, 1'b0});
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R8 reset mid readout", 13'b0);

        // R1: fresh start after reset works
        start_in = 1'b1;
        step();
        start_in = 1'b0;
        chk("R1 start after reset", {1'b1, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end

endmodule